// File: doc/BRIEF.md
# Widening Vector Multiply and Q15 Unit

This block is a 128-bit integer vector multiplier with three kinds of operation. The extending multiply takes either the lower or the upper half of the lanes of two vectors. It multiplies corresponding lanes and writes each product into a lane twice as wide, so the result vector holds half as many lanes. The signed 16-bit dot product multiplies all eight 16-bit lane pairs. It then adds each neighbouring pair of products into one of four 32-bit lanes. The Q15 multiply treats each 16-bit lane as a signed fraction, rounds the product to nearest and clamps it to the 16-bit range.

The block is one pipeline stage. An operation offered with `inValid` high is decoded and computed in the same cycle. Its result appears on `result` one clock later with `outValid`. A control module turns the operation fields into a small set of strobes, and a datapath module carries out the arithmetic and holds the output register.

Top module: `vmw_top`

## Requirements
- R1: While `rstN` is low and after its release, `outValid` is 0 and `result` is all zeros until the first accepted operation.
- R2: `outValid` is high in exactly the cycle after a cycle with `inValid` high. The result of that operation is present on `result` in the same cycle.
- R3: When `inValid` is low, `result` keeps its previous value, whatever the other inputs do.
- R4: With `opSel`=0 and `laneShape`=0 (8-bit lanes), output 16-bit lane i (bits 16i+15..16i) is the product of input 8-bit lanes i (when `hiHalf`=0) or i+8 (when `hiHalf`=1). Input lane j occupies bits 8j+7..8j.
- R5: With `opSel`=0 and `laneShape`=1 (16-bit lanes), output 32-bit lane i is the product of input 16-bit lanes i or i+4, as selected by `hiHalf`.
- R6: With `opSel`=0 and `laneShape`=2 (32-bit lanes), output 64-bit lane i is the product of input 32-bit lanes i or i+2, as selected by `hiHalf`.
- R7: For the extending multiply, `isSigned`=1 reads lanes as two's complement and `isSigned`=0 reads them as unsigned.
- R8: With `opSel`=1, output 32-bit lane k is a[2k]*b[2k] + a[2k+1]*b[2k+1] modulo 2^32, where a and b are the signed 16-bit lanes. When all four factors are -32768, the lane is 0x80000000. `hiHalf`, `laneShape` and `isSigned` have no effect.
- R9: With `opSel`=2, each output 16-bit lane j is floor((a[j]*b[j] + 16384) / 32768) of the signed 16-bit inputs. `hiHalf`, `laneShape` and `isSigned` have no effect.
- R10: In the Q15 multiply, -32768 times -32768 gives 0x7FFF, and no lane ever outputs 0x8000.
- R11: With `opSel`=3, or with `opSel`=0 and `laneShape`=3, an accepted operation gives an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operation offered this cycle |
| opA | input | 128 | First operand vector |
| opB | input | 128 | Second operand vector |
| opSel | input | 2 | 0 extending multiply, 1 dot product, 2 Q15 multiply, 3 reserved |
| hiHalf | input | 1 | Extending multiply takes the upper half of the lanes |
| laneShape | input | 2 | Input lane width: 0 8-bit, 1 16-bit, 2 32-bit, 3 reserved |
| isSigned | input | 1 | Extending multiply reads lanes as signed |
| outValid | output | 1 | Result of the previous cycle's operation is valid |
| result | output | 128 | Result vector |

## Verification
The rarest situations are the two overflow corners. In the Q15 multiply, only one lane pair out of 2^32 saturates. In the dot product, only one combination of four factors reaches 0x80000000. Random operands would almost never reach either. The stimulus therefore builds vectors from a fixed set of boundary values (0, ±1, extremes and their neighbours), crosses every pair of them, and adds dedicated all-minimum vectors. The 8-bit extending multiply is swept over every operand pair, both halves and both signednesses.

// File: rtl/vmw_pkg.sv
package vmw_pkg;

  typedef enum logic [1:0] {
    OP_EXTMUL = 2'd0,
    OP_DOT    = 2'd1,
    OP_Q15    = 2'd2,
    OP_RSVD   = 2'd3
  } opKind_t;

  typedef enum logic [1:0] {
    SH_B8   = 2'd0,
    SH_B16  = 2'd1,
    SH_B32  = 2'd2,
    SH_RSVD = 2'd3
  } laneShape_t;

  // strobes handed from control to datapath
  typedef struct packed {
    logic load;
    logic selExt8;
    logic selExt16;
    logic selExt32;
    logic selDot;
    logic selQ15;
    logic useHigh;
    logic signedMul;
  } dpStrobe_t;

endpackage

// File: rtl/vmw_ctrl.sv
module vmw_ctrl
  import vmw_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] opSel,
  input  logic [1:0] laneShape,
  input  logic       hiHalf,
  input  logic       isSigned,
  output dpStrobe_t  strobe
);

  always_comb begin
    strobe           = '0;
    strobe.load      = inValid;
    strobe.useHigh   = hiHalf;
    strobe.signedMul = isSigned;
    case (opKind_t'(opSel))
      OP_EXTMUL: begin
        case (laneShape_t'(laneShape))
          SH_B8:   strobe.selExt8  = 1'b1;
          SH_B16:  strobe.selExt16 = 1'b1;
          SH_B32:  strobe.selExt32 = 1'b1;
          default: ;
        endcase
      end
      OP_DOT:  strobe.selDot = 1'b1;
      OP_Q15:  strobe.selQ15 = 1'b1;
      default: ;
    endcase
  end

  // R11: at most one result group is ever chosen, none for reserved codes
  always_comb begin
    a_r11_sel_onehot: assert ($onehot0({strobe.selExt8, strobe.selExt16,
                                        strobe.selExt32, strobe.selDot,
                                        strobe.selQ15}));
  end

endmodule

// File: rtl/vmw_extmul.sv
module vmw_extmul #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic             useHigh,
  input  logic             signedMul,
  output logic [VEC_W-1:0] prod
);

  localparam int NLANE = VEC_W / LANE_W;
  localparam int HALF  = NLANE / 2;
  localparam int WIDE  = 2 * LANE_W;

  for (genvar i = 0; i < HALF; i++) begin : g_lane
    logic [LANE_W-1:0] aLane, bLane;
    logic [WIDE-1:0]   aWide, bWide;

    assign aLane = useHigh ? opA[(i+HALF)*LANE_W +: LANE_W] : opA[i*LANE_W +: LANE_W];
    assign bLane = useHigh ? opB[(i+HALF)*LANE_W +: LANE_W] : opB[i*LANE_W +: LANE_W];

    // extend to double width; the low half of the product is exact for both signednesses
    assign aWide = {{LANE_W{signedMul & aLane[LANE_W-1]}}, aLane};
    assign bWide = {{LANE_W{signedMul & bLane[LANE_W-1]}}, bLane};

    assign prod[i*WIDE +: WIDE] = aWide * bWide;
  end

endmodule

// File: rtl/vmw_datapath.sv
module vmw_datapath
  import vmw_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);

  localparam int H_W   = 16;
  localparam int N16   = VEC_W / H_W;
  localparam int NDOT  = N16 / 2;
  localparam int P_W   = 2 * H_W;
  localparam int Q_SH  = H_W - 1;

  logic [VEC_W-1:0] ext8Res, ext16Res, ext32Res, dotRes, q15Res, nextRes;

  // extending multiplies, one instance per lane shape
  for (genvar s = 0; s < 3; s++) begin : g_ext
    logic [VEC_W-1:0] part;
    vmw_extmul #(.VEC_W(VEC_W), .LANE_W(8 << s)) i_extmul (
      .opA      (opA),
      .opB      (opB),
      .useHigh  (strobe.useHigh),
      .signedMul(strobe.signedMul),
      .prod     (part)
    );
  end
  assign ext8Res  = g_ext[0].part;
  assign ext16Res = g_ext[1].part;
  assign ext32Res = g_ext[2].part;

  // signed 16-bit products shared by dot product and Q15
  logic signed [P_W-1:0] hProd [N16];
  for (genvar j = 0; j < N16; j++) begin : g_hprod
    logic signed [P_W-1:0] aExt, bExt;
    assign aExt     = {{H_W{opA[j*H_W+H_W-1]}}, opA[j*H_W +: H_W]};
    assign bExt     = {{H_W{opB[j*H_W+H_W-1]}}, opB[j*H_W +: H_W]};
    assign hProd[j] = aExt * bExt;
  end

  // dot product: pairwise sum, wraps modulo 2^32
  for (genvar k = 0; k < NDOT; k++) begin : g_dot
    assign dotRes[k*P_W +: P_W] = hProd[2*k] + hProd[2*k+1];
  end

  // Q15: add half an LSB, shift, clamp
  for (genvar j = 0; j < N16; j++) begin : g_q15
    logic signed [P_W:0] qRnd, qShf;
    assign qRnd = {hProd[j][P_W-1], hProd[j]} + 33'sd16384;
    assign qShf = qRnd >>> Q_SH;
    always_comb begin
      if (qShf > 33'sd32767)
        q15Res[j*H_W +: H_W] = 16'h7FFF;
      else if (qShf < -33'sd32768)
        q15Res[j*H_W +: H_W] = 16'h8000;
      else
        q15Res[j*H_W +: H_W] = qShf[H_W-1:0];
    end
  end

  always_comb begin
    nextRes = '0;
    if (strobe.selExt8)       nextRes = ext8Res;
    else if (strobe.selExt16) nextRes = ext16Res;
    else if (strobe.selExt32) nextRes = ext32Res;
    else if (strobe.selDot)   nextRes = dotRes;
    else if (strobe.selQ15)   nextRes = q15Res;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) result <= nextRes;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid);

  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !outValid);

  a_r3_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(result));

  a_r11_rsvd_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !(strobe.selExt8 || strobe.selExt16 || strobe.selExt32 ||
                      strobe.selDot || strobe.selQ15)) |=> (result == '0));

  for (genvar j = 0; j < N16; j++) begin : g_q15chk
    a_r10_q15_no_min: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.load && strobe.selQ15) |=> (result[j*H_W +: H_W] != 16'h8000));
  end

endmodule

// File: rtl/vmw_top.sv
module vmw_top
  import vmw_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [1:0]       opSel,
  input  logic             hiHalf,
  input  logic [1:0]       laneShape,
  input  logic             isSigned,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);

  dpStrobe_t strobe;

  vmw_ctrl i_ctrl (
    .inValid  (inValid),
    .opSel    (opSel),
    .laneShape(laneShape),
    .hiHalf   (hiHalf),
    .isSigned (isSigned),
    .strobe   (strobe)
  );

  vmw_datapath #(.VEC_W(VEC_W)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .outValid(outValid),
    .result  (result)
  );

endmodule

// File: tb/test_vmw_top.sv
`timescale 1ns/1ps
module test_vmw_top;

  localparam int CLK_NS = 20;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] opA = '0, opB = '0;
  logic [1:0]   opSel = 2'd0;
  logic         hiHalf = 1'b0;
  logic [1:0]   laneShape = 2'd0;
  logic         isSigned = 1'b0;
  logic         outValid;
  logic [127:0] result;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  vmw_top i_vmw_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .opSel(opSel), .hiHalf(hiHalf), .laneShape(laneShape), .isSigned(isSigned),
    .outValid(outValid), .result(result)
  );

  function automatic longint getLane(logic [127:0] v, int idx, int w, bit sgn);
    longint x = 0;
    for (int k = 0; k < w; k++) x[k] = v[idx*w + k];
    if (sgn && v[idx*w + w - 1]) x = x - (longint'(1) << w);
    return x;
  endfunction

  function automatic logic [127:0] mdlExt(logic [127:0] a, logic [127:0] b,
                                          int shape, bit hi, bit sgn);
    logic [127:0] r = '0;
    int w = 8 << shape;
    int n = 128 / w;
    for (int i = 0; i < n/2; i++) begin
      int src = hi ? i + n/2 : i;
      longint p = getLane(a, src, w, sgn) * getLane(b, src, w, sgn);
      for (int k = 0; k < 2*w; k++) r[i*2*w + k] = p[k];
    end
    return r;
  endfunction

  function automatic logic [127:0] mdlDot(logic [127:0] a, logic [127:0] b);
    logic [127:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      longint s = getLane(a, 2*k, 16, 1'b1) * getLane(b, 2*k, 16, 1'b1)
                + getLane(a, 2*k+1, 16, 1'b1) * getLane(b, 2*k+1, 16, 1'b1);
      for (int t = 0; t < 32; t++) r[k*32 + t] = s[t];
    end
    return r;
  endfunction

  function automatic logic [127:0] mdlQ15(logic [127:0] a, logic [127:0] b);
    logic [127:0] r = '0;
    for (int j = 0; j < 8; j++) begin
      longint num = getLane(a, j, 16, 1'b1) * getLane(b, j, 16, 1'b1) + 16384;
      longint q = (num >= 0) ? num / 32768 : -((-num + 32767) / 32768);
      if (q > 32767) q = 32767;
      if (q < -32768) q = -32768;
      for (int t = 0; t < 16; t++) r[j*16 + t] = q[t];
    end
    return r;
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // drive at a falling edge, sample at the following falling edge
  task automatic runOp(logic [127:0] a, logic [127:0] b, logic [1:0] op,
                       bit hi, logic [1:0] sh, bit sgn);
    inValid = 1'b1; opA = a; opB = b; opSel = op; hiHalf = hi;
    laneShape = sh; isSigned = sgn;
    @(negedge clk);
  endtask

  function automatic logic [15:0] corner(int idx);
    case (idx % 16)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'hFFFF;
      3: return 16'h7FFF;  4: return 16'h8000;  5: return 16'h8001;
      6: return 16'h7FFE;  7: return 16'h4000;  8: return 16'hC000;
      9: return 16'h00FF;  10: return 16'hFF00; 11: return 16'h0080;
      12: return 16'hFF80; 13: return 16'h3FFF; 14: return 16'hC001;
      default: return 16'h5555;
    endcase
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog got timeout exp completion");
    finishRun();
  end

  initial begin
    logic [127:0] a, b, held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid in reset", {127'd0, outValid}, '0);
    check("R1 result in reset", result, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {127'd0, outValid}, '0);
    check("R1 result after reset", result, '0);

    // R2: valid one cycle after an accepted op
    runOp(128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10, 128'h1111_2222_3333_4444_5555_6666_7777_8888,
          2'd2, 1'b0, 2'd0, 1'b0);
    check("R2 valid", {127'd0, outValid}, 128'd1);
    held = result;
    // R3: hold while idle, other inputs changing
    inValid = 1'b0; opA = rnd128(); opB = rnd128(); opSel = 2'd0;
    @(negedge clk);
    check("R2 valid drops", {127'd0, outValid}, '0);
    check("R3 hold", result, held);
    opA = rnd128(); opSel = 2'd1;
    @(negedge clk);
    check("R3 hold again", result, held);

    // R4 R7: exhaustive 8-bit pairs, both halves and signednesses
    for (int sgn = 0; sgn < 2; sgn++)
      for (int hi = 0; hi < 2; hi++)
        for (int av = 0; av < 256; av++)
          for (int bg = 0; bg < 32; bg++) begin
            for (int i = 0; i < 16; i++) begin
              a[i*8 +: 8] = (i < 8) ? 8'(av) : ~8'(av);
              b[i*8 +: 8] = 8'(bg*8 + (i % 8));
            end
            runOp(a, b, 2'd0, hi[0], 2'd0, sgn[0]);
            check(sgn ? "R4 R7 ext8 signed" : "R4 ext8 unsigned", result,
                  mdlExt(a, b, 0, hi[0], sgn[0]));
          end

    // R5 R6 R7: 16-bit and 32-bit shapes, corners then random
    for (int sh = 1; sh < 3; sh++)
      for (int n = 0; n < 1500; n++) begin
        a = rnd128(); b = rnd128();
        if (n < 256)
          for (int j = 0; j < 8; j++) begin
            a[j*16 +: 16] = corner(n + j);
            b[j*16 +: 16] = corner(n / 16 + j * 3);
          end
        runOp(a, b, 2'd0, n[0], 2'(sh), n[1]);
        check(sh == 1 ? "R5 R7 ext16" : "R6 R7 ext32", result,
              mdlExt(a, b, sh, n[0], n[1]));
      end

    // R8: dot product incl. overflow corner, other fields varied
    a = {8{16'h8000}};
    runOp(a, a, 2'd1, 1'b1, 2'd3, 1'b0);
    check("R8 dot overflow", result, {4{32'h8000_0000}});
    for (int n = 0; n < 2000; n++) begin
      a = rnd128(); b = rnd128();
      if (n < 256)
        for (int j = 0; j < 8; j++) begin
          a[j*16 +: 16] = corner(n + j);
          b[j*16 +: 16] = corner(n / 16 + j);
        end
      runOp(a, b, 2'd1, n[0], 2'(n[2:1]), n[3]);
      check("R8 dot", result, mdlDot(a, b));
    end

    // R9 R10: Q15 across all corner pairs and random
    a = {8{16'h8000}};
    runOp(a, a, 2'd2, 1'b0, 2'd0, 1'b1);
    check("R10 q15 saturate", result, {8{16'h7FFF}});
    for (int n = 0; n < 2256; n++) begin
      a = rnd128(); b = rnd128();
      if (n < 256)
        for (int j = 0; j < 8; j++) begin
          a[j*16 +: 16] = corner(n);
          b[j*16 +: 16] = corner(n / 16 + j);
        end
      runOp(a, b, 2'd2, n[0], 2'(n[2:1]), n[3]);
      check("R9 R10 q15", result, mdlQ15(a, b));
    end

    // R11: reserved codes give zero
    runOp({8{16'h7FFF}}, {8{16'h7FFF}}, 2'd3, 1'b0, 2'd0, 1'b1);
    check("R11 rsvd op", result, '0);
    runOp({8{16'h7FFF}}, {8{16'h7FFF}}, 2'd2, 1'b0, 2'd0, 1'b1);
    runOp({8{16'h7FFF}}, {8{16'h7FFF}}, 2'd0, 1'b1, 2'd3, 1'b1);
    check("R11 rsvd shape", result, '0);

    inValid = 1'b0;
    @(negedge clk);
    finishRun();
  end

endmodule